// File: doc/BRIEF.md
# Sector Erase Collection Window and Suspend Controller

This block governs a flash device from the moment a full sector-erase command sequence has been decoded until the erase finishes. It opens a collection window. Each further sector-erase byte (30h) written while the window is open adds that sector to the set and restarts the window. When a parameterised number of microsecond ticks passes with no new sector, the block closes the window and pulses a start to the erase engine. The engine then erases every collected sector together.

The suspend byte (B0h) interrupts a sector erase, either during the window or while the engine runs. The resume byte (30h) continues the erase on the same sector set. While the erase is suspended, the block tells the surrounding logic whether a given sector may be read or programmed. Only sectors outside the erase set are allowed.

The command decoder upstream supplies a strobe for a complete sector-erase sequence and a strobe with the data byte for every other single-cycle command write. The timing of the erase itself belongs to the engine, which reports back through a done strobe.

Top module: `sector_erase_ctrl`

## Requirements
- R1: After reset the sector mask is zero, the window, start, run and suspended outputs are low, and access_ok_o is high.
- R2: In idle, a se_start_i strobe opens the window on the next cycle and sets the mask to the one-hot of sector_i, with bit n standing for sector n.
- R3: While the window is open, a write with wr_data_i = 30h (or a se_start_i) ORs the one-hot of sector_i into the mask and restarts the window. The window closes and erase_start_o rises exactly WIN_US tick_us_i ticks after the last accepted sector.
- R4: erase_start_o is high for a single cycle. erase_run_o is high from that cycle until the engine reports done.
- R5: In idle, a write of 30h is not accepted: the window stays closed and the mask stays zero.
- R6: While the window is open, a write of any byte other than 30h or B0h returns the block to idle and clears the mask, with no erase start.
- R7: A write of B0h while the window is open closes the window on the next cycle and raises suspended_o with no erase start. A following 30h write pulses erase_start_o and runs the erase on the unchanged mask.
- R8: A write of B0h while the erase runs drops erase_run_o and raises suspended_o. A following 30h write raises erase_run_o again with no new erase_start_o pulse and with the unchanged mask. sector_i has no effect on suspend or resume.
- R9: In idle, a write of B0h is ignored, because suspend applies only to a sector erase.
- R10: access_ok_o is high in idle and low while the window is open or the erase runs. While the erase is suspended, it is high exactly when bit acc_sector_i of the mask is zero.
- R11: eng_done_i while the erase runs returns the block to idle and clears the mask. While the erase is suspended, eng_done_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| se_start_i | input | 1 | Complete sector-erase sequence decoded |
| wr_i | input | 1 | Single-cycle command write strobe |
| wr_data_i | input | 8 | Data byte of the command write |
| sector_i | input | SW | Sector addressed by the current command |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| eng_done_i | input | 1 | Erase engine finished |
| acc_sector_i | input | SW | Sector of a pending read or program access |
| sec_mask_o | output | NSEC | Collected sector set |
| erase_start_o | output | 1 | One-cycle start to the erase engine |
| erase_run_o | output | 1 | Engine may run |
| suspended_o | output | 1 | Erase is suspended |
| window_o | output | 1 | Collection window is open |
| access_ok_o | output | 1 | Access to acc_sector_i is allowed |

## Verification
The hardest case to reach is a suspend that cuts the window short, followed by a resume. Only that resume must still produce the erase start, which has never fired. The stimulus opens a window, adds a sector, sends B0h mid-window with a stray sector address, and then resumes. Near-exhaustive sweeps over every pair of sectors in a four-sector configuration check the window length after each restart. Sweeps of every access sector while suspended check the access gating.

// File: rtl/sew_pkg.sv
// Shared types and command codes for the sector erase window controller.
// Assumes command bytes arrive already decoded from the bus write cycle.
package sew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WIN   = 2'd1,
        ST_ERASE = 2'd2,
        ST_SUSP  = 2'd3
    } sew_state_t;

    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
endpackage

// File: rtl/sew_win_timer.sv
// Window timer: counts microsecond ticks since the last accepted sector.
// Flags expiry on the WIN_US-th tick. Assumes WIN_US >= 1.
module sew_win_timer #(
    parameter int WIN_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = (WIN_US < 2) ? 1 : $clog2(WIN_US);
    localparam logic [CW-1:0] LAST = CW'(WIN_US - 1);

    logic [CW-1:0] cnt_q;

    // Expiry is combinational so the controller acts on the same tick.
    assign expire = run && tick && (cnt_q == LAST);

    // Count ticks while the window runs; restart zeroes the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (restart || !run)         cnt_q <= '0;
        else if (tick && !expire)         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sew_sector_set.sv
// Sector set: one bit per sector, set by add, cleared as a whole.
// Also reports whether the probed sector is a member. Assumes NSEC >= 2.
module sew_sector_set #(
    parameter int NSEC = 8,
    localparam int SW = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            add,
    input  logic [SW-1:0]   sector,
    input  logic [SW-1:0]   probe,
    output logic [NSEC-1:0] mask,
    output logic            hit
);
    for (genvar g = 0; g < NSEC; g++) begin : g_bit
        // Each bit is set when its sector is added, and cleared on clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                    mask[g] <= 1'b0;
            else if (add && sector == SW'(g))       mask[g] <= 1'b1;
        end
    end

    // Membership of the probed sector.
    assign hit = mask[probe];
endmodule

// File: rtl/sector_erase_ctrl.sv
// Sector erase collection window and suspend controller.
// Gathers sectors during a restartable window, then starts the erase engine.
// Handles suspend and resume. Assumes single-cycle strobes from the decoder.
module sector_erase_ctrl
    import sew_pkg::*;
#(
    parameter int NSEC   = 8,
    parameter int WIN_US = 50,
    localparam int SW = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            se_start_i,
    input  logic            wr_i,
    input  logic [7:0]      wr_data_i,
    input  logic [SW-1:0]   sector_i,
    input  logic            tick_us_i,
    input  logic            eng_done_i,
    input  logic [SW-1:0]   acc_sector_i,
    output logic [NSEC-1:0] sec_mask_o,
    output logic            erase_start_o,
    output logic            erase_run_o,
    output logic            suspended_o,
    output logic            window_o,
    output logic            access_ok_o
);
    sew_state_t st_q, st_d;
    logic started_q, started_d;
    logic start_d;
    logic add, clear, restart, expire, hit;
    logic wr_sec, wr_sus;

    assign wr_sec = wr_i && (wr_data_i == CMD_SECTOR);
    assign wr_sus = wr_i && (wr_data_i == CMD_SUSPEND);

    sew_win_timer #(.WIN_US(WIN_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st_q == ST_WIN),
        .restart(restart), .tick(tick_us_i), .expire(expire)
    );

    sew_sector_set #(.NSEC(NSEC)) u_set (
        .clk(clk), .rst_n(rst_n), .clear(clear), .add(add),
        .sector(sector_i), .probe(acc_sector_i),
        .mask(sec_mask_o), .hit(hit)
    );

    // Next-state decision for commands, window expiry and engine completion.
    always_comb begin
        st_d      = st_q;
        started_d = started_q;
        start_d   = 1'b0;
        add       = 1'b0;
        clear     = 1'b0;
        restart   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (se_start_i) begin
                    st_d    = ST_WIN;
                    add     = 1'b1;
                    restart = 1'b1;
                end
            end
            ST_WIN: begin
                if (se_start_i || wr_sec) begin
                    add     = 1'b1;
                    restart = 1'b1;
                end else if (wr_sus) begin
                    st_d      = ST_SUSP;
                    started_d = 1'b0;
                end else if (wr_i) begin
                    st_d  = ST_IDLE;
                    clear = 1'b1;
                end else if (expire) begin
                    st_d      = ST_ERASE;
                    start_d   = 1'b1;
                    started_d = 1'b1;
                end
            end
            ST_ERASE: begin
                if (eng_done_i) begin
                    st_d  = ST_IDLE;
                    clear = 1'b1;
                end else if (wr_sus) begin
                    st_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (wr_sec) begin
                    st_d      = ST_ERASE;
                    start_d   = !started_q;
                    started_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, started flag and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= ST_IDLE;
            started_q     <= 1'b0;
            erase_start_o <= 1'b0;
        end else begin
            st_q          <= st_d;
            started_q     <= started_d;
            erase_start_o <= start_d;
        end
    end

    assign window_o    = (st_q == ST_WIN);
    assign erase_run_o = (st_q == ST_ERASE);
    assign suspended_o = (st_q == ST_SUSP);
    assign access_ok_o = (st_q == ST_IDLE) || ((st_q == ST_SUSP) && !hit);
endmodule

// File: rtl/sector_erase_ctrl_chk.sv
// Checker for sector_erase_ctrl: port-level temporal properties.
// Attached to every instance by the bind below.
module sector_erase_ctrl_chk #(
    parameter int NSEC = 8,
    parameter int SW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            se_start_i,
    input logic            wr_i,
    input logic [7:0]      wr_data_i,
    input logic            eng_done_i,
    input logic [NSEC-1:0] sec_mask_o,
    input logic            erase_start_o,
    input logic            erase_run_o,
    input logic            suspended_o,
    input logic            window_o
);
    // R4
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({window_o, erase_run_o, suspended_o}));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_o |=> !erase_start_o);

    // R7
    win_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o && wr_i && wr_data_i == 8'hB0 && !se_start_i)
        |=> (suspended_o && !window_o && !erase_start_o));

    // R6
    win_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o && wr_i && wr_data_i != 8'h30 && wr_data_i != 8'hB0 && !se_start_i)
        |=> (sec_mask_o == '0 && !window_o && !erase_start_o));

    // R11
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run_o && eng_done_i) |=> (sec_mask_o == '0 && !erase_run_o));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((erase_run_o || suspended_o) && !eng_done_i) |=> $stable(sec_mask_o));

    // R5
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_o && !erase_run_o && !suspended_o && !se_start_i)
        |=> (!window_o && sec_mask_o == '0));
endmodule

bind sector_erase_ctrl sector_erase_ctrl_chk #(.NSEC(NSEC), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .se_start_i(se_start_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .eng_done_i(eng_done_i), .sec_mask_o(sec_mask_o),
    .erase_start_o(erase_start_o), .erase_run_o(erase_run_o),
    .suspended_o(suspended_o), .window_o(window_o)
);

// File: tb/sim_sector_erase_ctrl.sv
module sim_sector_erase_ctrl;
    localparam int NSEC = 4;
    localparam int WIN_US = 5;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic se_start_i = 1'b0, wr_i = 1'b0, tick_us_i = 1'b0, eng_done_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [SW-1:0] sector_i = '0, acc_sector_i = '0;
    logic [NSEC-1:0] sec_mask_o;
    logic erase_start_o, erase_run_o, suspended_o, window_o, access_ok_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sector_erase_ctrl #(.NSEC(NSEC), .WIN_US(WIN_US)) u0 (
        .clk(clk), .rst_n(rst_n), .se_start_i(se_start_i), .wr_i(wr_i),
        .wr_data_i(wr_data_i), .sector_i(sector_i), .tick_us_i(tick_us_i),
        .eng_done_i(eng_done_i), .acc_sector_i(acc_sector_i),
        .sec_mask_o(sec_mask_o), .erase_start_o(erase_start_o),
        .erase_run_o(erase_run_o), .suspended_o(suspended_o),
        .window_o(window_o), .access_ok_o(access_ok_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] d, input int sec);
        wr_i = 1'b1; wr_data_i = d; sector_i = SW'(sec);
        step();
        wr_i = 1'b0; wr_data_i = 8'h00;
    endtask

    task automatic open_win(input int sec);
        se_start_i = 1'b1; sector_i = SW'(sec);
        step();
        se_start_i = 1'b0;
    endtask

    // Ticks every cycle until the start pulse; returns the tick count.
    task automatic run_to_start(output int n);
        n = 0;
        tick_us_i = 1'b1;
        while (!erase_start_o && n < 4 * WIN_US) begin
            step();
            n++;
        end
        tick_us_i = 1'b0;
    endtask

    task automatic finish_erase();
        eng_done_i = 1'b1;
        step();
        eng_done_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        int exp_mask;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1
        chk(sec_mask_o == 0 && !window_o && !erase_start_o && !erase_run_o
            && !suspended_o && access_ok_o, "R1 reset", int'(sec_mask_o), 0);

        // R2 R3 R4 R11: every pair of sectors
        for (int a = 0; a < NSEC; a++) begin
            for (int b = 0; b < NSEC; b++) begin
                open_win(a);
                chk(window_o && sec_mask_o == NSEC'(1 << a), "R2 open",
                    int'(sec_mask_o), 1 << a);
                chk(!access_ok_o, "R10 window", int'(access_ok_o), 0);
                cmd(8'h30, b);
                exp_mask = (1 << a) | (1 << b);
                chk(sec_mask_o == NSEC'(exp_mask), "R3 add", int'(sec_mask_o), exp_mask);
                run_to_start(n);
                chk(n == WIN_US, "R3 window length", n, WIN_US);
                chk(erase_run_o && !window_o, "R4 run", int'(erase_run_o), 1);
                step();
                chk(!erase_start_o && erase_run_o, "R4 pulse", int'(erase_start_o), 0);
                finish_erase();
                chk(sec_mask_o == 0 && !erase_run_o, "R11 done", int'(sec_mask_o), 0);
            end
        end

        // R3 restart after partial window
        open_win(0);
        tick_us_i = 1'b1;
        repeat (WIN_US - 2) step();
        tick_us_i = 1'b0;
        cmd(8'h30, 3);
        run_to_start(n);
        chk(n == WIN_US, "R3 restart", n, WIN_US);
        chk(sec_mask_o == 4'b1001, "R3 mask", int'(sec_mask_o), 9);
        finish_erase();

        // R5 late sector byte in idle
        cmd(8'h30, 2);
        chk(!window_o && sec_mask_o == 0, "R5 idle 30h", int'(sec_mask_o), 0);

        // R9 suspend in idle
        cmd(8'hB0, 1);
        chk(!suspended_o && access_ok_o, "R9 idle B0h", int'(suspended_o), 0);

        // R6 abort with other commands
        for (int c = 0; c < 4; c++) begin
            open_win(c);
            cmd(8'hF0 - 8'(c * 16), c);
            chk(!window_o && sec_mask_o == 0 && !erase_run_o, "R6 abort",
                int'(sec_mask_o), 0);
        end

        // R7 suspend inside window, then resume
        open_win(1);
        cmd(8'h30, 2);
        tick_us_i = 1'b1;
        cmd(8'hB0, 3);
        tick_us_i = 1'b0;
        chk(suspended_o && !window_o && !erase_start_o, "R7 suspend",
            int'(suspended_o), 1);
        chk(sec_mask_o == 4'b0110, "R7 mask", int'(sec_mask_o), 6);
        for (int s = 0; s < NSEC; s++) begin
            acc_sector_i = SW'(s);
            #1;
            chk(access_ok_o == !(s == 1 || s == 2), "R10 suspended access",
                int'(access_ok_o), int'(!(s == 1 || s == 2)));
        end
        finish_erase();
        chk(suspended_o && sec_mask_o == 4'b0110, "R11 done ignored",
            int'(sec_mask_o), 6);
        cmd(8'h30, 0);
        chk(erase_start_o && erase_run_o && sec_mask_o == 4'b0110, "R7 resume",
            int'(erase_start_o), 1);

        // R8 suspend while running, resume without new start
        step();
        chk(!access_ok_o, "R10 running", int'(access_ok_o), 0);
        cmd(8'hB0, 0);
        chk(suspended_o && !erase_run_o, "R8 suspend", int'(erase_run_o), 0);
        acc_sector_i = SW'(3);
        #1;
        chk(access_ok_o, "R10 free sector", int'(access_ok_o), 1);
        cmd(8'h30, 3);
        chk(erase_run_o && !erase_start_o && sec_mask_o == 4'b0110, "R8 resume",
            int'(erase_start_o), 0);
        finish_erase();
        chk(!erase_run_o && sec_mask_o == 0 && access_ok_o, "R11 final",
            int'(sec_mask_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule